// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block governs the run state of a single DMA channel. The channel is disabled, enabled or paused, and a separate error flag overrides the reported state code. Software-facing control bits arrive as a write strobe that carries an enable bit, a continue request and a select bit that picks where a paused channel resumes. The block holds the current source and destination descriptor pointers. It reloads them from the start addresses or steps the source pointer to the following descriptor.

Fetching descriptors and moving data happen outside this block. Both appear here only as handshakes. A completion pulse arrives with the finished descriptor's command field and interrupt bit. An error pulse reports a failed descriptor fetch. A mode input selects simple (register-programmed) operation or chained descriptor operation. For each completion the controller raises one-cycle event pulses: a transfer-done pulse, a source-done pulse and a pause pulse.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset `stateCode` is 0 and `enOut`, `contOut`, all event pulses and both pointers are 0. `stateCode` encodes 0 = disabled, 1 = enabled, 2 = paused. It reads 3 whenever the error flag is set, whatever the underlying state.
- R2: A control write with `ctrlEn`=1 while disabled copies `srcStart` and `dstStart` into `srcCurPtr` and `dstCurPtr`. The state becomes enabled on the next cycle.
- R3: A control write with `ctrlEn`=1 and `ctrlCont`=1 while paused, with `ctrlContAddr`=1, reloads both pointers from the start inputs, clears `contOut` and enables the channel.
- R4: The same resume write with `ctrlContAddr`=0 advances `srcCurPtr` by `DSC_BYTES` and leaves `dstCurPtr` unchanged. It also clears `contOut` and enables the channel. A write with `ctrlEn`=1 and `ctrlCont`=0 leaves a paused channel paused.
- R5: A control write with `ctrlEn`=0 and `ctrlCont`=1 while paused disables the channel and leaves `contOut` at 1. With `ctrlCont`=0 the channel stays paused.
- R6: A completion in simple mode (`simpleMode`=1), or with command 2 (stop), clears `enOut` and disables the channel.
- R7: A completion in descriptor mode with command 1 (halt) pauses the channel and pulses `pauseEvt` for one cycle.
- R8: A completion in descriptor mode with command 0 or 3 advances `srcCurPtr` by `DSC_BYTES` and keeps the channel enabled.
- R9: A fetch error while enabled sets the error flag, so `stateCode` reads 3. The underlying state becomes disabled. A later control write with `ctrlEn`=1 clears the flag and starts the channel as from disabled.
- R10: Every accepted completion pulses `dmaDoneEvt`. `srcDoneEvt` pulses only when `dscIntr` is 1.
- R11: Completion and fetch-error pulses are ignored unless `stateCode` is 1. In a cycle with a control write they are ignored and the write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlEn | input | 1 | Enable bit written |
| ctrlCont | input | 1 | Continue request written |
| ctrlContAddr | input | 1 | Resume select: 1 = from start, 0 = next descriptor |
| simpleMode | input | 1 | 1 = simple register mode, 0 = descriptor mode |
| dscDone | input | 1 | Descriptor completion pulse |
| dscCmd | input | 2 | Command of the completed descriptor |
| dscIntr | input | 1 | Interrupt bit of the completed descriptor |
| fetchErr | input | 1 | Descriptor fetch error pulse |
| srcStart | input | ADDR_W | Source start address |
| dstStart | input | ADDR_W | Destination start address |
| stateCode | output | 2 | Run state code |
| enOut | output | 1 | Current enable bit |
| contOut | output | 1 | Current continue bit |
| pauseEvt | output | 1 | Pause event pulse |
| dmaDoneEvt | output | 1 | Transfer-done event pulse |
| srcDoneEvt | output | 1 | Source-done event pulse |
| srcCurPtr | output | ADDR_W | Current source descriptor pointer |
| dstCurPtr | output | ADDR_W | Current destination descriptor pointer |

## Verification
The hardest situation to reach is the resume from pause, because it needs a prior halt completion in descriptor mode. The pointers must also already differ from the start addresses, so that a reload and an advance give different values. The stimulus table first runs two advancing completions and a halt. It then resumes with the next-descriptor select, halts again and resumes with the start select, which makes the two outcomes visible on `srcCurPtr`. A further row applies a control write and a stop completion in the same cycle to expose the write's priority.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } run_state_e;

  localparam logic [1:0] CODE_ERR = 2'd3;
  localparam logic [1:0] CMD_HALT = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  typedef struct packed {
    logic loadStart;
    logic advSrc;
  } ptr_cmd_t;

endpackage

// File: rtl/dma_run_fsm.sv
module dma_run_fsm
  import dma_run_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlEn,
  input  logic       ctrlCont,
  input  logic       ctrlContAddr,
  input  logic       simpleMode,
  input  logic       dscDone,
  input  logic [1:0] dscCmd,
  input  logic       dscIntr,
  input  logic       fetchErr,
  output ptr_cmd_t   ptrCmd,
  output logic [1:0] stateCode,
  output logic       enOut,
  output logic       contOut,
  output logic       pauseEvt,
  output logic       dmaDoneEvt,
  output logic       srcDoneEvt
);

  run_state_e stateQ, stateD;
  logic errQ, errD;
  logic enQ, enD;
  logic contQ, contD;
  logic pauseD, doneD, srcDoneD;
  logic running;

  assign running = (stateQ == ST_RUN) && !errQ;

  always_comb begin
    stateD   = stateQ;
    errD     = errQ;
    enD      = enQ;
    contD    = contQ;
    pauseD   = 1'b0;
    doneD    = 1'b0;
    srcDoneD = 1'b0;
    ptrCmd   = '0;
    if (ctrlWr) begin
      enD   = ctrlEn;
      contD = ctrlCont;
      if (ctrlEn) begin
        errD = 1'b0;
        if (stateQ == ST_HOLD && ctrlCont) begin
          if (ctrlContAddr) begin
            ptrCmd.loadStart = 1'b1;
          end else begin
            ptrCmd.advSrc = 1'b1;
          end
          contD  = 1'b0;
          stateD = ST_RUN;
        end else if (stateQ == ST_OFF) begin
          ptrCmd.loadStart = 1'b1;
          stateD = ST_RUN;
        end
      end else if (stateQ == ST_HOLD && ctrlCont) begin
        stateD = ST_OFF;
      end
    end else if (running) begin
      if (fetchErr) begin
        errD   = 1'b1;
        stateD = ST_OFF;
      end else if (dscDone) begin
        doneD    = 1'b1;
        srcDoneD = dscIntr;
        if (simpleMode || dscCmd == CMD_STOP) begin
          enD    = 1'b0;
          stateD = ST_OFF;
        end else if (dscCmd == CMD_HALT) begin
          stateD = ST_HOLD;
          pauseD = 1'b1;
        end else begin
          ptrCmd.advSrc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_OFF;
      errQ       <= 1'b0;
      enQ        <= 1'b0;
      contQ      <= 1'b0;
      pauseEvt   <= 1'b0;
      dmaDoneEvt <= 1'b0;
      srcDoneEvt <= 1'b0;
    end else begin
      stateQ     <= stateD;
      errQ       <= errD;
      enQ        <= enD;
      contQ      <= contD;
      pauseEvt   <= pauseD;
      dmaDoneEvt <= doneD;
      srcDoneEvt <= srcDoneD;
    end
  end

  assign stateCode = errQ ? CODE_ERR : stateQ;
  assign enOut     = enQ;
  assign contOut   = contQ;

endmodule

// File: rtl/dma_run_ptrs.sv
module dma_run_ptrs
  import dma_run_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DSC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptr_cmd_t          ptrCmd,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  output logic [ADDR_W-1:0] srcCurPtr,
  output logic [ADDR_W-1:0] dstCurPtr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DSC_BYTES);

  logic [ADDR_W-1:0] srcQ, dstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (ptrCmd.loadStart) begin
      srcQ <= srcStart;
      dstQ <= dstStart;
    end else if (ptrCmd.advSrc) begin
      srcQ <= srcQ + STEP;
    end
  end

  assign srcCurPtr = srcQ;
  assign dstCurPtr = dstQ;

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_run_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DSC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              ctrlEn,
  input  logic              ctrlCont,
  input  logic              ctrlContAddr,
  input  logic              simpleMode,
  input  logic              dscDone,
  input  logic [1:0]        dscCmd,
  input  logic              dscIntr,
  input  logic              fetchErr,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  output logic [1:0]        stateCode,
  output logic              enOut,
  output logic              contOut,
  output logic              pauseEvt,
  output logic              dmaDoneEvt,
  output logic              srcDoneEvt,
  output logic [ADDR_W-1:0] srcCurPtr,
  output logic [ADDR_W-1:0] dstCurPtr
);

  ptr_cmd_t ptrCmd;

  dma_run_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWr      (ctrlWr),
    .ctrlEn      (ctrlEn),
    .ctrlCont    (ctrlCont),
    .ctrlContAddr(ctrlContAddr),
    .simpleMode  (simpleMode),
    .dscDone     (dscDone),
    .dscCmd      (dscCmd),
    .dscIntr     (dscIntr),
    .fetchErr    (fetchErr),
    .ptrCmd      (ptrCmd),
    .stateCode   (stateCode),
    .enOut       (enOut),
    .contOut     (contOut),
    .pauseEvt    (pauseEvt),
    .dmaDoneEvt  (dmaDoneEvt),
    .srcDoneEvt  (srcDoneEvt)
  );

  dma_run_ptrs #(
    .ADDR_W   (ADDR_W),
    .DSC_BYTES(DSC_BYTES)
  ) u_ptrs (
    .clk      (clk),
    .rstN     (rstN),
    .ptrCmd   (ptrCmd),
    .srcStart (srcStart),
    .dstStart (dstStart),
    .srcCurPtr(srcCurPtr),
    .dstCurPtr(dstCurPtr)
  );

endmodule

// File: rtl/dma_run_ctrl_chk.sv
module dma_run_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int DSC_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic              ctrlEn,
  input logic              ctrlCont,
  input logic              ctrlContAddr,
  input logic              simpleMode,
  input logic              dscDone,
  input logic [1:0]        dscCmd,
  input logic              dscIntr,
  input logic              fetchErr,
  input logic [ADDR_W-1:0] srcStart,
  input logic [ADDR_W-1:0] dstStart,
  input logic [1:0]        stateCode,
  input logic              enOut,
  input logic              contOut,
  input logic              pauseEvt,
  input logic              dmaDoneEvt,
  input logic              srcDoneEvt,
  input logic [ADDR_W-1:0] srcCurPtr,
  input logic [ADDR_W-1:0] dstCurPtr
);

  logic accept;
  assign accept = (stateCode == 2'd1) && !ctrlWr && !fetchErr && dscDone;

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlEn && stateCode == 2'd0) |=>
      (stateCode == 2'd1 && srcCurPtr == $past(srcStart) && dstCurPtr == $past(dstStart)));

  a_r3_resume_start: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlEn && ctrlCont && ctrlContAddr && stateCode == 2'd2) |=>
      (stateCode == 2'd1 && !contOut && srcCurPtr == $past(srcStart)));

  a_r4_resume_next: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlEn && ctrlCont && !ctrlContAddr && stateCode == 2'd2) |=>
      (stateCode == 2'd1 && !contOut && srcCurPtr == $past(srcCurPtr) + ADDR_W'(DSC_BYTES)
       && $stable(dstCurPtr)));

  a_r5_leave_pause: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !ctrlEn && ctrlCont && stateCode == 2'd2) |=> (stateCode == 2'd0));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (simpleMode || dscCmd == 2'd2)) |=> (stateCode == 2'd0 && !enOut));

  a_r7_halt: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !simpleMode && dscCmd == 2'd1) |=> (stateCode == 2'd2 && pauseEvt));

  a_r8_advance: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !simpleMode && (dscCmd == 2'd0 || dscCmd == 2'd3)) |=>
      (stateCode == 2'd1 && srcCurPtr == $past(srcCurPtr) + ADDR_W'(DSC_BYTES)));

  a_r9_error: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd1 && !ctrlWr && fetchErr) |=> (stateCode == 2'd3));

  a_r10_events: assert property (@(posedge clk) disable iff (!rstN)
    (pauseEvt || srcDoneEvt) |-> dmaDoneEvt);

  a_r11_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 2'd1 || ctrlWr) |=> (!dmaDoneEvt && !pauseEvt && !srcDoneEvt));

endmodule

bind dma_run_ctrl dma_run_ctrl_chk #(.ADDR_W(ADDR_W), .DSC_BYTES(DSC_BYTES)) u_chk (.*);

// File: tb/dma_run_ctrl_tb.sv
module dma_run_ctrl_tb;

  localparam int ADDR_W = 32;
  localparam int DSC    = 16;
  localparam logic [31:0] SRC0 = 32'h1000;
  localparam logic [31:0] DST0 = 32'h2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, ctrlEn = 0, ctrlCont = 0, ctrlContAddr = 0;
  logic simpleMode = 0, dscDone = 0, dscIntr = 0, fetchErr = 0;
  logic [1:0] dscCmd = 0;
  logic [ADDR_W-1:0] srcStart = SRC0, dstStart = DST0;
  logic [1:0] stateCode;
  logic enOut, contOut, pauseEvt, dmaDoneEvt, srcDoneEvt;
  logic [ADDR_W-1:0] srcCurPtr, dstCurPtr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_run_ctrl #(.ADDR_W(ADDR_W), .DSC_BYTES(DSC)) u_dut (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic        wr, en, cont, ca, done;
    logic [1:0]  cmd;
    logic        intr, simple, ferr;
    logic [1:0]  eCode;
    logic        eEn, eCont, ePause, eDone, eSrcDone;
    logic [31:0] eSrc;
  } vec_t;

  localparam int NV = 22;
  // req wr en co ca dn cmd in si fe code eEn eCo ePa eDn eSd src
  localparam vec_t TBL [NV] = '{
    '{8'd2, 1,1,0,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R2 start
    '{8'd8, 0,0,0,0, 1,2'd0,1,0,0, 2'd1, 1,0, 0,1,1, 32'h1010}, // R8 R10 cmd 0
    '{8'd8, 0,0,0,0, 1,2'd3,0,0,0, 2'd1, 1,0, 0,1,0, 32'h1020}, // R8 R10 cmd 3
    '{8'd7, 0,0,0,0, 1,2'd1,0,0,0, 2'd2, 1,0, 1,1,0, 32'h1020}, // R7 halt
    '{8'd11,0,0,0,0, 1,2'd0,1,0,0, 2'd2, 1,0, 0,0,0, 32'h1020}, // R11 ignored when paused
    '{8'd4, 1,1,0,0, 0,2'd0,0,0,0, 2'd2, 1,0, 0,0,0, 32'h1020}, // R4 no cont stays paused
    '{8'd4, 1,1,1,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1030}, // R4 resume next
    '{8'd7, 0,0,0,0, 1,2'd1,1,0,0, 2'd2, 1,0, 1,1,1, 32'h1030}, // R7 halt again
    '{8'd3, 1,1,1,1, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R3 resume start
    '{8'd6, 0,0,0,0, 1,2'd2,1,0,0, 2'd0, 0,0, 0,1,1, 32'h1000}, // R6 stop
    '{8'd11,0,0,0,0, 1,2'd0,0,0,0, 2'd0, 0,0, 0,0,0, 32'h1000}, // R11 ignored when off
    '{8'd2, 1,1,0,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R2 restart
    '{8'd6, 0,0,0,0, 1,2'd0,0,1,0, 2'd0, 0,0, 0,1,0, 32'h1000}, // R6 simple mode
    '{8'd2, 1,1,0,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R2
    '{8'd7, 0,0,0,0, 1,2'd1,0,0,0, 2'd2, 1,0, 1,1,0, 32'h1000}, // R7
    '{8'd5, 1,0,1,0, 0,2'd0,0,0,0, 2'd0, 0,1, 0,0,0, 32'h1000}, // R5 leave pause
    '{8'd2, 1,1,0,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R2
    '{8'd9, 0,0,0,0, 0,2'd0,0,0,1, 2'd3, 1,0, 0,0,0, 32'h1000}, // R9 fetch error
    '{8'd11,0,0,0,0, 1,2'd0,0,0,0, 2'd3, 1,0, 0,0,0, 32'h1000}, // R11 ignored on error
    '{8'd9, 1,1,0,0, 0,2'd0,0,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R9 error cleared
    '{8'd11,1,1,0,0, 1,2'd2,1,0,0, 2'd1, 1,0, 0,0,0, 32'h1000}, // R11 write priority
    '{8'd6, 0,0,0,0, 1,2'd2,0,0,0, 2'd0, 0,0, 0,1,0, 32'h1000}  // R6
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, en, co, ca, dn, input logic [1:0] cmd,
                       input logic intr, si, fe);
    @(negedge clk);
    ctrlWr = wr; ctrlEn = en; ctrlCont = co; ctrlContAddr = ca;
    dscDone = dn; dscCmd = cmd; dscIntr = intr; simpleMode = si; fetchErr = fe;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, "reset code", 32'(stateCode), 0);
    chk(1, "reset en", 32'(enOut), 0);
    chk(1, "reset cont", 32'(contOut), 0);
    chk(1, "reset events", {29'd0, pauseEvt, dmaDoneEvt, srcDoneEvt}, 0);
    chk(1, "reset src", srcCurPtr, 0);
    chk(1, "reset dst", dstCurPtr, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      drive(v.wr, v.en, v.cont, v.ca, v.done, v.cmd, v.intr, v.simple, v.ferr);
      chk(v.req, $sformatf("row %0d code", i), 32'(stateCode), 32'(v.eCode));
      chk(v.req, $sformatf("row %0d en", i), 32'(enOut), 32'(v.eEn));
      chk(v.req, $sformatf("row %0d cont", i), 32'(contOut), 32'(v.eCont));
      chk(v.req, $sformatf("row %0d pause", i), 32'(pauseEvt), 32'(v.ePause));
      chk(v.req, $sformatf("row %0d done", i), 32'(dmaDoneEvt), 32'(v.eDone));
      chk(v.req, $sformatf("row %0d srcdone", i), 32'(srcDoneEvt), 32'(v.eSrcDone));
      chk(v.req, $sformatf("row %0d src", i), srcCurPtr, v.eSrc);
      chk(v.req, $sformatf("row %0d dst", i), dstCurPtr, DST0);
    end
    idle();

    // R5: enable low without continue keeps a paused channel paused
    drive(1, 1, 0, 0, 0, 2'd0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 2'd1, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    chk(5, "paused, no cont, enable low", 32'(stateCode), 2);
    idle();
    chk(5, "pause event one cycle", 32'(pauseEvt), 0);

    // R2: changed start inputs are copied on the next start
    drive(1, 0, 1, 0, 0, 2'd0, 0, 0, 0);
    srcStart = 32'h4440; dstStart = 32'h5550;
    drive(1, 1, 0, 0, 0, 2'd0, 0, 0, 0);
    chk(2, "new src start", srcCurPtr, 32'h4440);
    chk(2, "new dst start", dstCurPtr, 32'h5550);

    // R1: reset returns everything to its initial state mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chk(1, "reset mid-run code", 32'(stateCode), 0);
    chk(1, "reset mid-run src", srcCurPtr, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule